// File: doc/BRIEF.md
# Capture Channel Input Routing

This block is the input side of one capture/compare channel of a timer. A two-bit direction field decides whether the channel works as an output or as an input. As an input it takes its events from one of three lines: the channel's own filtered input, the filtered input of the neighbouring channel, or an internal trigger line. The chosen line is turned into an edge-event stream, on rising edges only or on both edges. A capture prescaler then passes on one event out of every 1, 2, 4 or 8 as a single-cycle capture strobe.

Software loads the direction, prescaler and edge-mode fields through a simple write port. A direction write is accepted only while the channel is disabled. The prescaler and edge-mode fields can be changed at any time. Clearing the channel enable holds the prescaler count at zero, so every enable starts a fresh count. The capture register and the counter that uses the strobe belong to the surrounding timer.

Top module: `cap_route`

## Requirements
- R1: After reset the direction field is 00 (output), the prescaler code is 00, edge mode is rising-only, and `cap_strobe` is 0.
- R2: With direction code 00 (output) no capture strobe is produced, whatever the three event inputs do.
- R3: Direction code 01 takes events from `own_in`. The other two inputs have no effect.
- R4: Direction code 10 takes events from `nbr_in`. The other two inputs have no effect.
- R5: Direction code 11 takes events from `trig_in` only while `trig_ok` is 1. While `trig_ok` is 0 no strobe is produced.
- R6: A write with `wr_en`=1 while `ch_en`=1 leaves the direction field unchanged. The prescaler and edge fields of that write still take effect.
- R7: Prescaler code 00 strobes on every event, 01 on every 2nd, 10 on every 4th and 11 on every 8th. After an enable, the first strobe for ratio k comes on the k-th event, and the count then returns to zero.
- R8: While `ch_en` is 0 the prescaler count is held at zero and no strobe is produced.
- R9: `cap_strobe` is a registered one-cycle pulse. An event on the selected input in the clock cycle before edge n gives `cap_strobe`=1 from edge n until edge n+1.
- R10: A prescaler write takes effect from the next event. If the count already reached is at or above the new ratio minus one, that next event strobes and the count returns to zero.
- R11: Edge code 0 counts only 0-to-1 transitions of the selected input. Edge code 1 counts both 0-to-1 and 1-to-0 transitions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the configuration fields |
| wr_dir | input | 2 | Direction code: 00 output, 01 own, 10 neighbour, 11 trigger |
| wr_psc | input | 2 | Prescaler code: ratio is 2 to the power of the code |
| wr_both | input | 1 | Edge code: 0 rising only, 1 both edges |
| ch_en | input | 1 | Channel enable |
| trig_ok | input | 1 | An internal trigger is selected, so the trigger line is usable |
| own_in | input | 1 | Filtered input of this channel |
| nbr_in | input | 1 | Filtered input of the neighbouring channel |
| trig_in | input | 1 | Internal trigger line |
| cap_strobe | output | 1 | Capture strobe, one cycle wide |

## Verification
An input change driven before clock edge n is seen as an event at edge n, and `cap_strobe` rises at that same edge and falls at edge n+1. A configuration write applied at edge n changes the routing seen by events from edge n+1 onward. The bench drives inputs on falling edges. A behavioural model updates at every rising edge, using the same inputs and the same write-before-use ordering, and its strobe is compared with the design's at every falling edge, half a cycle after the strobe settles. Directed phases also count strobes over groups of pulses, and each count is read two cycles after the last pulse so the last strobe is always included.

// File: rtl/cap_route_pkg.sv
// Package: shared codes for the capture channel input routing block.
// Assumes a two-bit direction field whose code values are decoded by the
// timer's other logic, so the values below are fixed.
package cap_route_pkg;
    typedef enum logic [1:0] {
        DIR_OUTPUT = 2'b00,
        DIR_OWN    = 2'b01,
        DIR_NBR    = 2'b10,
        DIR_TRIG   = 2'b11
    } dir_e;

    // Index of each candidate event line inside the edge bank.
    localparam int SRC_OWN  = 0;
    localparam int SRC_NBR  = 1;
    localparam int SRC_TRIG = 2;
    localparam int NUM_SRC  = 3;
endpackage

// File: rtl/cap_cfg_reg.sv
// Module: configuration fields of the channel front end.
// Holds the direction, prescaler and edge-mode fields. The direction field
// is locked while the channel is enabled. The other fields can be written
// at any time. Assumes writes are synchronous single-cycle strobes.
module cap_cfg_reg
    import cap_route_pkg::*;
#(
    parameter int PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_dir,
    input  logic [PSC_W-1:0] wr_psc,
    input  logic             wr_both,
    input  logic             ch_en,
    output dir_e             dir_q,
    output logic [PSC_W-1:0] psc_q,
    output logic             both_q
);
    // Direction field: loaded only while the channel is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= DIR_OUTPUT;
        end else if (wr_en && !ch_en) begin
            dir_q <= dir_e'(wr_dir);
        end
    end

    // Prescaler and edge fields: loaded on any write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_q  <= '0;
            both_q <= 1'b0;
        end else if (wr_en) begin
            psc_q  <= wr_psc;
            both_q <= wr_both;
        end
    end
endmodule

// File: rtl/cap_edge_bank.sv
// Module: edge detection for every candidate event line.
// Each line keeps its previous level. An event is a 0-to-1 transition, or
// any transition when both-edge mode is set. Assumes the inputs are already
// synchronous to clk (filtered upstream).
module cap_edge_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         both,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] evt
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_line
        // Remember the level of line i from the previous cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q[i] <= 1'b0;
            end else begin
                prev_q[i] <= lvl[i];
            end
        end

        // Flag a transition on line i according to the edge mode.
        always_comb begin
            if (both) begin
                evt[i] = lvl[i] ^ prev_q[i];
            end else begin
                evt[i] = lvl[i] & ~prev_q[i];
            end
        end
    end
endmodule

// File: rtl/cap_src_mux.sv
// Module: picks the event stream that feeds the capture prescaler.
// Output direction gives no events. The trigger line is used only while the
// trigger-select qualifier is set.
module cap_src_mux
    import cap_route_pkg::*;
(
    input  dir_e               dir,
    input  logic               trig_ok,
    input  logic [NUM_SRC-1:0] evt,
    output logic               evt_sel
);
    // Decode the direction code into one event stream.
    always_comb begin
        unique case (dir)
            DIR_OWN:  evt_sel = evt[SRC_OWN];
            DIR_NBR:  evt_sel = evt[SRC_NBR];
            DIR_TRIG: evt_sel = evt[SRC_TRIG] & trig_ok;
            default:  evt_sel = 1'b0;
        endcase
    end
endmodule

// File: rtl/cap_prescaler.sv
// Module: capture prescaler with a registered strobe.
// Counts events and strobes on every 2^psc-th one. The count is held at zero
// while the channel is disabled. A count at or above the current limit
// strobes on the next event, so a smaller ratio written mid-count takes
// effect at once.
module cap_prescaler #(
    parameter int PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             evt,
    input  logic [PSC_W-1:0] psc,
    output logic [(1<<PSC_W)-2:0] cnt_q,
    output logic             strobe_q
);
    localparam int CNT_W = (1 << PSC_W) - 1;

    logic [CNT_W:0] ratio;
    logic [CNT_W:0] limit;
    logic           at_limit;

    // Ratio and terminal-count compare for the current prescaler code.
    always_comb begin
        ratio    = (CNT_W+1)'(1) << psc;
        limit    = ratio - (CNT_W+1)'(1);
        at_limit = ({1'b0, cnt_q} >= limit);
    end

    // Event counter and one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q    <= '0;
            strobe_q <= 1'b0;
        end else if (evt) begin
            if (at_limit) begin
                cnt_q    <= '0;
                strobe_q <= 1'b1;
            end else begin
                cnt_q    <= cnt_q + CNT_W'(1);
                strobe_q <= 1'b0;
            end
        end else begin
            strobe_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cap_route.sv
// Module: top of the capture channel input routing block.
// Connects the configuration fields, the edge bank, the source mux and the
// prescaler. Assumes all inputs are synchronous to clk.
module cap_route
    import cap_route_pkg::*;
#(
    parameter int PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_dir,
    input  logic [PSC_W-1:0] wr_psc,
    input  logic             wr_both,
    input  logic             ch_en,
    input  logic             trig_ok,
    input  logic             own_in,
    input  logic             nbr_in,
    input  logic             trig_in,
    output logic             cap_strobe
);
    localparam int CNT_W = (1 << PSC_W) - 1;

    dir_e               cfg_dir;
    logic [PSC_W-1:0]   cfg_psc;
    logic               cfg_both;
    logic [NUM_SRC-1:0] lvl;
    logic [NUM_SRC-1:0] evt;
    logic               evt_sel;
    logic [CNT_W-1:0]   psc_cnt;

    // Pack the candidate lines in bank order.
    always_comb begin
        lvl           = '0;
        lvl[SRC_OWN]  = own_in;
        lvl[SRC_NBR]  = nbr_in;
        lvl[SRC_TRIG] = trig_in;
    end

    cap_cfg_reg #(.PSC_W(PSC_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_dir  (wr_dir),
        .wr_psc  (wr_psc),
        .wr_both (wr_both),
        .ch_en   (ch_en),
        .dir_q   (cfg_dir),
        .psc_q   (cfg_psc),
        .both_q  (cfg_both)
    );

    cap_edge_bank #(.N(NUM_SRC)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .both  (cfg_both),
        .lvl   (lvl),
        .evt   (evt)
    );

    cap_src_mux u_mux (
        .dir     (cfg_dir),
        .trig_ok (trig_ok),
        .evt     (evt),
        .evt_sel (evt_sel)
    );

    cap_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ch_en),
        .evt      (evt_sel),
        .psc      (cfg_psc),
        .cnt_q    (psc_cnt),
        .strobe_q (cap_strobe)
    );
endmodule

// File: rtl/cap_route_chk.sv
// Module: property checker for cap_route, attached by bind below.
// Watches the ports together with the configuration fields and the
// prescaler count.
module cap_route_chk #(
    parameter int PSC_W = 2,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ch_en,
    input logic             trig_ok,
    input logic [1:0]       dir,
    input logic [PSC_W-1:0] psc,
    input logic [CNT_W-1:0] cnt,
    input logic             cap_strobe
);
    AST_DIR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ch_en |=> (dir == $past(dir)));                                  // R6

    AST_OUTPUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dir == 2'b00) |=> !cap_strobe);                                 // R2

    AST_TRIG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (dir == 2'b11 && !trig_ok) |=> !cap_strobe);                     // R5

    AST_OFF_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en |=> (!cap_strobe && cnt == '0));                          // R8

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_strobe && psc != '0) |=> !cap_strobe);                      // R9
endmodule

bind cap_route cap_route_chk #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ch_en      (ch_en),
    .trig_ok    (trig_ok),
    .dir        (cfg_dir),
    .psc        (cfg_psc),
    .cnt        (psc_cnt),
    .cap_strobe (cap_strobe)
);

// File: tb/cap_route_tb_top.sv
module cap_route_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_dir = 2'b00;
    logic [1:0] wr_psc = 2'b00;
    logic       wr_both = 1'b0;
    logic       ch_en = 1'b0;
    logic       trig_ok = 1'b0;
    logic       own_in = 1'b0;
    logic       nbr_in = 1'b0;
    logic       trig_in = 1'b0;
    logic       cap_strobe;

    int    n_checks = 0;
    int    n_fails = 0;
    int    n_strobes = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // behavioural reference state
    int m_dir = 0, m_psc = 0, m_both = 0, m_cnt = 0;
    int m_strobe = 0;
    int m_prev [3] = '{0, 0, 0};

    always #4ns clk = ~clk;   // 125 MHz

    cap_route dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dir(wr_dir),
        .wr_psc(wr_psc), .wr_both(wr_both), .ch_en(ch_en),
        .trig_ok(trig_ok), .own_in(own_in), .nbr_in(nbr_in),
        .trig_in(trig_in), .cap_strobe(cap_strobe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // reference model: evaluate with old state, then apply writes
    always @(posedge clk) begin
        int lv [3];
        int ev, sel_ev, ratio;
        lv[0] = int'(own_in); lv[1] = int'(nbr_in); lv[2] = int'(trig_in);
        if (!rst_n) begin
            m_dir = 0; m_psc = 0; m_both = 0; m_cnt = 0; m_strobe = 0;
            for (int i = 0; i < 3; i++) m_prev[i] = 0;
        end else begin
            sel_ev = 0;
            for (int i = 0; i < 3; i++) begin
                ev = m_both ? int'(lv[i] != m_prev[i]) : int'(lv[i] == 1 && m_prev[i] == 0);
                if (m_dir == i + 1 && (i != 2 || trig_ok)) sel_ev = ev;
            end
            ratio = 1 << m_psc;
            if (!ch_en) begin
                m_cnt = 0; m_strobe = 0;
            end else if (sel_ev != 0) begin
                if (m_cnt >= ratio - 1) begin m_cnt = 0; m_strobe = 1; end
                else begin m_cnt++; m_strobe = 0; end
            end else m_strobe = 0;
            if (wr_en) begin
                m_psc = int'(wr_psc); m_both = int'(wr_both);
                if (!ch_en) m_dir = int'(wr_dir);
            end
            for (int i = 0; i < 3; i++) m_prev[i] = lv[i];
        end
    end

    // per-cycle comparison and strobe counting, half a cycle after the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(int'(cap_strobe) == m_strobe, cur_req, int'(cap_strobe), m_strobe);
            if (cap_strobe) n_strobes++;
        end
    end

    initial begin
        #(8ns * 150000);
        n_fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input int d, input int p, input int b);
        wr_en = 1'b1; wr_dir = 2'(d); wr_psc = 2'(p); wr_both = b[0];
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int which, input int n);
        for (int k = 0; k < n; k++) begin
            if (which == 0) own_in = 1'b1; else if (which == 1) nbr_in = 1'b1; else trig_in = 1'b1;
            tick(1);
            if (which == 0) own_in = 1'b0; else if (which == 1) nbr_in = 1'b0; else trig_in = 1'b0;
            tick(1);
        end
    endtask

    task automatic count_pulses(input int which, input int n, input int exp, input string req);
        int base;
        cur_req = req;
        tick(1);
        base = n_strobes;
        pulse(which, n);
        tick(2);
        check(n_strobes - base == exp, req, n_strobes - base, exp);
    endtask

    task automatic reconfig(input int d, input int p, input int b);
        ch_en = 1'b0;
        tick(1);
        cfg(d, p, b);
        ch_en = 1'b1;
        tick(1);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check(cap_strobe == 1'b0, "R1", int'(cap_strobe), 0);
        // R1: default direction is output, so pulses give nothing
        ch_en = 1'b1;
        count_pulses(0, 3, 0, "R1");
        count_pulses(1, 3, 0, "R2");
        count_pulses(2, 3, 0, "R2");

        reconfig(1, 0, 0);
        count_pulses(0, 4, 4, "R3");
        count_pulses(1, 3, 0, "R3");
        count_pulses(2, 3, 0, "R3");

        reconfig(2, 0, 0);
        count_pulses(1, 3, 3, "R4");
        count_pulses(0, 3, 0, "R4");

        trig_ok = 1'b1;
        reconfig(3, 0, 0);
        count_pulses(2, 2, 2, "R5");
        count_pulses(0, 2, 0, "R5");
        trig_ok = 1'b0;
        count_pulses(2, 2, 0, "R5");

        // R6: direction write while enabled is dropped, prescaler write applies
        trig_ok = 1'b1;
        cfg(1, 1, 0);
        count_pulses(0, 2, 0, "R6");
        count_pulses(2, 4, 2, "R6");

        for (int p = 0; p < 4; p++) begin
            reconfig(1, p, 0);
            count_pulses(0, (1 << p) - 1, 0, "R7");
            count_pulses(0, 1, 1, "R7");
            count_pulses(0, 8, 8 >> p, "R7");
        end

        // R8: disabling mid-count clears it
        reconfig(1, 3, 0);
        count_pulses(0, 5, 0, "R8");
        ch_en = 1'b0;
        count_pulses(0, 2, 0, "R8");
        ch_en = 1'b1;
        count_pulses(0, 7, 0, "R8");
        count_pulses(0, 1, 1, "R8");

        // R9: strobe timing and width
        cur_req = "R9";
        reconfig(1, 0, 0);
        own_in = 1'b1;
        tick(1);
        check(cap_strobe == 1'b1, "R9", int'(cap_strobe), 1);
        tick(1);
        check(cap_strobe == 1'b0, "R9", int'(cap_strobe), 0);
        own_in = 1'b0;
        tick(2);

        // R10: ratio lowered mid-count takes effect on the next event
        reconfig(1, 3, 0);
        count_pulses(0, 3, 0, "R10");
        cfg(1, 1, 0);
        count_pulses(0, 1, 1, "R10");
        count_pulses(0, 4, 2, "R10");

        // R11: both-edge mode counts rise and fall
        reconfig(1, 0, 1);
        count_pulses(0, 3, 6, "R11");
        cfg(1, 0, 0);
        count_pulses(0, 3, 3, "R11");

        done = 1'b1;
        tick(2);
        finish_run();
    end
endmodule